// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a flash memory. After a program or erase command has been written, it decides when the operation has finished and whether it succeeded. A one-cycle `start` pulse makes it read the device status byte in pairs over a request/acknowledge read port. It compares the toggle bit (bit 6) of the two reads in each pair.

Equal toggle bits mean the operation is complete. If the toggle bit differs and the timeout flag (bit 5 of the later read) is high, the poller reads one more pair. This catches an operation that stopped toggling at the same moment the flag rose. If the toggle still moves on that recheck, the poller requests a reset-command write through a separate request/acknowledge port, and only then reports failure. A pair budget stops the poller from spinning forever on a device that keeps toggling with the flag low.

The result is a single-cycle `done` with `pass` or `fail` beside it. The poller is idle again in that same cycle.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `done`, `pass`, `fail`, `read_req` and `reset_cmd_req` are all low.
- R2: A `start` in idle begins a pair of reads. `read_req` stays high until `read_ack`, the byte on `read_data` is taken in the `read_ack` cycle, and each acknowledge ends exactly one read.
- R3: If bit 6 is equal in both bytes of a pair, the poller reports `done` with `pass`. It makes no reset request and issues no further reads until the next `start`.
- R4: If bit 6 differs and bit 5 of the second byte of the pair is low, the poller starts a new pair of reads.
- R5: If bit 6 differs and bit 5 of the second byte is high, exactly one recheck pair follows. If bit 6 is equal in that recheck pair, the result is `pass`.
- R6: If bit 6 still differs in the recheck pair, `reset_cmd_req` rises and stays high until `reset_cmd_ack`. `done` with `fail` follows in the next cycle.
- R7: With a pair limit of N (not zero), suppose pair N toggles with bit 5 low. The poller then requests the reset command and reports `fail` after 2N reads. A pair N with bit 5 high still gets its recheck pair.
- R8: A `start` while a poll is in progress is ignored: it issues no extra reads and produces no extra `done`.
- R9: `done` lasts exactly one cycle. `pass` and `fail` are high only together with `done`, and exactly one of them is high then.
- R10: Only bit 6 of both reads and bit 5 of the second read affect the decision. Bit 5 of the first read and all other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| read_req | output | 1 | Status read request, held until acknowledged |
| read_ack | input | 1 | Read acknowledge; `read_data` is valid in this cycle |
| read_data | input | 8 | Status byte returned by the device |
| reset_cmd_req | output | 1 | Request to write the reset command, held until acknowledged |
| reset_cmd_ack | input | 1 | Reset-command write acknowledge |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | Operation finished successfully (with `done`) |
| fail | output | 1 | Operation failed or the pair limit was hit (with `done`) |

## Verification
The bench feeds sequences that separate the recheck path from the plain retry path. One example is a first read carrying bit 5 while the second read does not. A poller that consulted the wrong byte would then recheck and report a spurious failure after four reads instead of passing after six.

The pair limit is probed on both sides of its boundary: one more toggling pair than allowed, exactly the allowed number, and a final pair with the flag raised. An off-by-one counter either fails a run that should pass or reads an extra pair. Bytes that differ only outside bit 6 must pass at once, and a stray `start` during a poll must not add reads. Read and reset-acknowledge counts are compared per run, so a poller that dropped the reset request or kept reading after `done` is caught.

// File: rtl/tpoll_pkg.sv
// Shared types for the toggle-bit completion poller.
package tpoll_pkg;

    // Controller sequence states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_JUDGE,
        ST_RST_CMD
    } tpoll_state_e;

    // Outcome of judging one completed pair of reads.
    typedef enum logic [2:0] {
        VD_PASS,
        VD_AGAIN,
        VD_RECHECK,
        VD_FAIL_TOGGLE,
        VD_FAIL_BUDGET
    } tpoll_verdict_e;

endpackage

// File: rtl/tpoll_sample_regs.sv
// Holds the status bits of the two reads of the current pair.
// Only the toggle bit of each read and the timeout bit of the second read
// are kept; the rest of the byte is dropped here on purpose.
// Assumes cap_a and cap_b are never high in the same cycle.
module tpoll_sample_regs #(
    parameter int DATA_W      = 8,
    parameter int TOGGLE_BIT  = 6,
    parameter int TIMEOUT_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_a,
    input  logic              cap_b,
    input  logic [DATA_W-1:0] din,
    output logic              tog_a,
    output logic              tog_b,
    output logic              tmo_b
);

    logic unused_din_bits;
    assign unused_din_bits = ^din;

    // Capture the relevant bits of each read of the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_a <= 1'b0;
            tog_b <= 1'b0;
            tmo_b <= 1'b0;
        end else begin
            if (cap_a) begin
                tog_a <= din[TOGGLE_BIT];
            end
            if (cap_b) begin
                tog_b <= din[TOGGLE_BIT];
                tmo_b <= din[TIMEOUT_BIT];
            end
        end
    end

endmodule

// File: rtl/tpoll_verdict.sv
// Combinational decision for one completed pair of reads.
// Assumes its inputs are stable while the controller is in its judge state.
module tpoll_verdict
    import tpoll_pkg::*;
(
    input  logic           tog_a,
    input  logic           tog_b,
    input  logic           tmo_b,
    input  logic           recheck,
    input  logic           budget_spent,
    output tpoll_verdict_e verdict
);

    logic toggled;
    assign toggled = tog_a ^ tog_b;

    // Rank the outcomes: a stable bit wins, then the recheck result, then the timeout flag, then the budget.
    always_comb begin
        if (!toggled) begin
            verdict = VD_PASS;
        end else if (recheck) begin
            verdict = VD_FAIL_TOGGLE;
        end else if (tmo_b) begin
            verdict = VD_RECHECK;
        end else if (budget_spent) begin
            verdict = VD_FAIL_BUDGET;
        end else begin
            verdict = VD_AGAIN;
        end
    end

endmodule

// File: rtl/tpoll_budget.sv
// Counts judged pairs since start and flags when the pair now being judged
// is the last one allowed. MAX_PAIRS = 0 turns the limit off.
// Assumes clear and bump are never high in the same cycle.
module tpoll_budget #(
    parameter int MAX_PAIRS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic spent
);

    localparam int CNT_W = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;
    localparam int LIMIT = (MAX_PAIRS > 0) ? MAX_PAIRS - 1 : 0;
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);
    localparam bit HAS_LIMIT = (MAX_PAIRS > 0);

    logic [CNT_W-1:0] cnt;

    // Saturating count of pairs already judged in this poll.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (bump && cnt != LIMIT_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign spent = HAS_LIMIT && (cnt == LIMIT_V);

    // R7: the counter never passes the last allowed pair index.
    assert_budget_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT_V);

endmodule

// File: rtl/toggle_poll_ctrl.sv
// Toggle-bit completion poller: reads the status byte in pairs after start,
// compares the toggle bit, rechecks once when the timeout flag is seen,
// and requests a reset-command write before reporting a failure.
// Assumes read_ack and reset_cmd_ack come only in response to their requests.
module toggle_poll_ctrl
    import tpoll_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TOGGLE_BIT  = 6,
    parameter int TIMEOUT_BIT = 5,
    parameter int MAX_PAIRS   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              read_req,
    input  logic              read_ack,
    input  logic [DATA_W-1:0] read_data,
    output logic              reset_cmd_req,
    input  logic              reset_cmd_ack,
    output logic              done,
    output logic              pass,
    output logic              fail
);

    tpoll_state_e   state;
    tpoll_verdict_e verdict;
    logic           recheck;
    logic           tog_a, tog_b, tmo_b;
    logic           budget_spent;
    logic           launch;

    assign launch        = (state == ST_IDLE) && start;
    assign read_req      = (state == ST_RD_A) || (state == ST_RD_B);
    assign reset_cmd_req = (state == ST_RST_CMD);

    tpoll_sample_regs #(
        .DATA_W     (DATA_W),
        .TOGGLE_BIT (TOGGLE_BIT),
        .TIMEOUT_BIT(TIMEOUT_BIT)
    ) u_samples (
        .clk  (clk),
        .rst_n(rst_n),
        .cap_a((state == ST_RD_A) && read_ack),
        .cap_b((state == ST_RD_B) && read_ack),
        .din  (read_data),
        .tog_a(tog_a),
        .tog_b(tog_b),
        .tmo_b(tmo_b)
    );

    tpoll_budget #(
        .MAX_PAIRS(MAX_PAIRS)
    ) u_budget (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(launch),
        .bump (state == ST_JUDGE),
        .spent(budget_spent)
    );

    tpoll_verdict u_verdict (
        .tog_a       (tog_a),
        .tog_b       (tog_b),
        .tmo_b       (tmo_b),
        .recheck     (recheck),
        .budget_spent(budget_spent),
        .verdict     (verdict)
    );

    // Sequence reads, judging, the reset request and the one-cycle result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            recheck <= 1'b0;
            done    <= 1'b0;
            pass    <= 1'b0;
            fail    <= 1'b0;
        end else begin
            done <= 1'b0;
            pass <= 1'b0;
            fail <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_RD_A;
                        recheck <= 1'b0;
                    end
                end
                ST_RD_A: begin
                    if (read_ack) state <= ST_RD_B;
                end
                ST_RD_B: begin
                    if (read_ack) state <= ST_JUDGE;
                end
                ST_JUDGE: begin
                    case (verdict)
                        VD_PASS: begin
                            done  <= 1'b1;
                            pass  <= 1'b1;
                            state <= ST_IDLE;
                        end
                        VD_AGAIN:   state <= ST_RD_A;
                        VD_RECHECK: begin
                            recheck <= 1'b1;
                            state   <= ST_RD_A;
                        end
                        default:    state <= ST_RST_CMD;
                    endcase
                end
                ST_RST_CMD: begin
                    if (reset_cmd_ack) begin
                        done  <= 1'b1;
                        fail  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a read request is held until it is acknowledged.
    assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (read_req && !read_ack) |=> read_req);

    // R6: the reset-command request is held until it is acknowledged.
    assert_rst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_cmd_req && !reset_cmd_ack) |=> reset_cmd_req);

    // R6: a failure is reported only right after an acknowledged reset command.
    assert_fail_after_rst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(reset_cmd_req && reset_cmd_ack));

    // R9: done is a single-cycle strobe.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: exactly one result flag accompanies done, none without it.
    assert_result_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pass, fail}) == (done ? 1 : 0));

    // R3: once done is raised, no read or reset request is outstanding.
    assert_quiet_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!read_req && !reset_cmd_req));

endmodule

// File: tb/tb_toggle_poll_ctrl.sv
`timescale 1ns/100ps
module tb_toggle_poll_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       read_req, read_ack = 1'b0;
    logic [7:0] read_data = 8'h00;
    logic       reset_cmd_req, reset_cmd_ack = 1'b0;
    logic       done, pass, fail;

    int total = 0;
    int fails = 0;
    int reads_cnt = 0;
    int rst_cnt = 0;
    int done_seen = 0;
    int cycles = 0;
    bit prev_done = 1'b0;

    logic [7:0] mem_q[$];
    bit         exp_pass_q[$];
    int         exp_reads_q[$];
    int         exp_rst_q[$];
    string      exp_req_q[$];

    always #2.5 clk = ~clk;

    toggle_poll_ctrl #(.MAX_PAIRS(4)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .read_req(read_req), .read_ack(read_ack), .read_data(read_data),
        .reset_cmd_req(reset_cmd_req), .reset_cmd_ack(reset_cmd_ack),
        .done(done), .pass(pass), .fail(fail)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Device model: one-cycle acknowledge per request, status bytes from a queue.
    always @(posedge clk) begin
        if (!rst_n) begin
            read_ack      <= 1'b0;
            reset_cmd_ack <= 1'b0;
        end else begin
            read_ack      <= 1'b0;
            reset_cmd_ack <= 1'b0;
            if (read_req && !read_ack) begin
                read_ack  <= 1'b1;
                read_data <= (mem_q.size() > 0) ? mem_q.pop_front() : 8'h00;
                reads_cnt = reads_cnt + 1;
            end
            if (reset_cmd_req && !reset_cmd_ack) begin
                reset_cmd_ack <= 1'b1;
                rst_cnt = rst_cnt + 1;
            end
        end
    end

    // Monitor: pop the expected result on each done and compare (R9 pulse width too).
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_pass_q.size() == 0) begin
                check(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
                automatic bit    ep  = exp_pass_q.pop_front();
                automatic int    er  = exp_reads_q.pop_front();
                automatic int    ers = exp_rst_q.pop_front();
                automatic string rq  = exp_req_q.pop_front();
                check(pass == ep, rq, "pass", int'(pass), int'(ep));
                check(fail == !ep, "R9", "fail", int'(fail), int'(!ep));
                check(reads_cnt == er, rq, "read count", reads_cnt, er);
                check(rst_cnt == ers, rq, "reset cmd count", rst_cnt, ers);
            end
            done_seen++;
            prev_done = 1'b1;
        end else if (prev_done) begin
            check(!done && !pass && !fail && !read_req, "R9", "done width / idle after",
                  int'({done, pass, fail, read_req}), 0);
            prev_done = 1'b0;
        end
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            total++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // Driver: load bytes, push the expected result, pulse start and wait for done.
    task automatic run_case(input logic [7:0] bytes[$], input bit ep, input int er,
                            input int ers, input string rq, input bit extra_start);
        automatic int target = done_seen + 1;
        mem_q     = bytes;
        reads_cnt = 0;
        rst_cnt   = 0;
        exp_pass_q.push_back(ep);
        exp_reads_q.push_back(er);
        exp_rst_q.push_back(ers);
        exp_req_q.push_back(rq);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (extra_start) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (done_seen < target) @(negedge clk);
        repeat (6) @(negedge clk);
        // R3: no further reads after completion.
        check(reads_cnt == er, "R3", "reads after done", reads_cnt, er);
        check(done_seen == target, "R8", "done count", done_seen, target);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs after reset.
        check(done == 1'b0, "R1", "done", int'(done), 0);
        check(pass == 1'b0, "R1", "pass", int'(pass), 0);
        check(fail == 1'b0, "R1", "fail", int'(fail), 0);
        check(read_req == 1'b0, "R1", "read_req", int'(read_req), 0);
        check(reset_cmd_req == 1'b0, "R1", "reset_cmd_req", int'(reset_cmd_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(read_req == 1'b0, "R2", "no read before start", int'(read_req), 0);

        // R2/R3: stable toggle bit on the first pair.
        run_case('{8'h40, 8'h40}, 1'b1, 2, 0, "R3", 1'b0);
        // R10: bytes differ only outside bit 6.
        run_case('{8'h01, 8'h80}, 1'b1, 2, 0, "R10", 1'b0);
        // R4: toggle with flag low, then stable.
        run_case('{8'h00, 8'h40, 8'h40, 8'h40}, 1'b1, 4, 0, "R4", 1'b0);
        // R5: toggle with flag high, recheck stable.
        run_case('{8'h00, 8'h60, 8'h20, 8'h20}, 1'b1, 4, 0, "R5", 1'b0);
        // R6: recheck still toggles.
        run_case('{8'h00, 8'h60, 8'h40, 8'h20}, 1'b0, 4, 1, "R6", 1'b0);
        // R10: flag only on the first read is ignored.
        run_case('{8'h20, 8'h40, 8'h00, 8'h40, 8'h00, 8'h00}, 1'b1, 6, 0, "R10", 1'b0);
        // R7: limit of 4 pairs exceeded.
        run_case('{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40},
                 1'b0, 8, 1, "R7", 1'b0);
        // R7: stable exactly on the last allowed pair.
        run_case('{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h40, 8'h40},
                 1'b1, 8, 0, "R7", 1'b0);
        // R7: flag on the last allowed pair still gets its recheck.
        run_case('{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h60, 8'h20, 8'h20},
                 1'b1, 10, 0, "R7", 1'b0);
        // R8: a start while busy adds no reads and no done.
        run_case('{8'h00, 8'h40, 8'h40, 8'h40}, 1'b1, 4, 0, "R8", 1'b1);

        check(exp_pass_q.size() == 0, "R9", "pending results", exp_pass_q.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule